// File: doc/BRIEF.md
# Rotary Encoder Delay-Time Control

This block turns a mechanical rotary encoder into a stepped delay setting for an audio delay line. The encoder's A and B lines are already debounced off-chip. The block samples them, together with a four-bit program-select switch, at a slow rate derived from the audio sample-frame tick. Sampling runs once every 64 frames by default.

At each sampling point, a low A line with the edge flag clear counts as one detent. The B line then gives the direction, and the 8-bit desired-delay high byte moves by one in that direction. One step of this byte is 256 audio samples, roughly 6 ms at the usual sample rates. The flag is sticky. It stays set while A remains low and clears only when A is seen high again, so each detent counts exactly once.

At every sampling point the switch value is also captured and converted into a program index for the effect dispatcher.

Top module: `enc_delay_ctrl`

## Requirements
- R1: After reset the desired-delay byte is 0, the program index is 2, the edge flag is clear, and the frame counter is loaded so that the 64th frame tick is the first sampling point.
- R2: Encoder and switch lines are examined only on every 64th frame tick. Between sampling points neither output changes, whatever the inputs do.
- R3: A sampling point that sees A high clears the edge flag, so the next sampling point that sees A low counts a new detent.
- R4: A sampling point that sees A low while the edge flag is already set leaves the delay byte unchanged, whatever the B level.
- R5: A counted detent with B low (right turn) raises the delay byte by 1.
- R6: A counted detent with B high (left turn) lowers the delay byte by 1.
- R7: The delay byte wraps modulo 256: a left turn at 0 gives 255, and a right turn at 255 gives 0.
- R8: At each sampling point the program index becomes 2 × switch + 2, for example switch 5 gives 12 and switch 15 gives 32. A switch change between sampling points does not show on the index until the next sampling point.
- R9: A and B each pass through two flip-flops before they are used. A level must therefore be held for at least two clocks before a sampling point to take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-clock pulse per audio sample frame |
| enc_a | input | 1 | Encoder A line, asynchronous |
| enc_b | input | 1 | Encoder B line, asynchronous |
| prog_sw | input | 4 | Program-select switch value |
| dly_hi | output | 8 | Desired-delay high byte (1 step = 256 samples) |
| prog_idx | output | 6 | Program index derived from the switch |

## Verification
The hardest case to reach from the ports is A held low across several sampling points, with B changing in between, while the sticky flag is already set. Only the absence of a second step shows that the flag works. The stimulus holds A low through two full 64-tick windows and flips B before the second window. It then lifts A for one window and lowers it again to show that the flag re-arms. The sampling cadence is probed by stopping one tick short of a window with a pending edge and checking that the output has not yet moved.

// File: rtl/enc_delay_ctrl.sv
module enc_delay_ctrl #(
  parameter int FRAME_DIV = 64,
  parameter int DLY_W     = 8,
  parameter int SW_W      = 4,
  parameter int IDX_W     = SW_W + 2,
  parameter int INIT_DLY  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [SW_W-1:0]  prog_sw,
  output logic [DLY_W-1:0] dly_hi,
  output logic [IDX_W-1:0] prog_idx
);
  localparam int CNT_W = $clog2(FRAME_DIV + 1);

  logic [1:0]       a_q, b_q;
  logic             a_s, b_s;
  logic [CNT_W-1:0] cnt;
  logic             sample_en;
  logic             edge_seen;
  logic             turn;

  assign a_s       = a_q[1];
  assign b_s       = b_q[1];
  assign sample_en = frame_tick && (cnt == CNT_W'(1));
  assign turn      = sample_en && !a_s && !edge_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 2'b11;
      b_q <= 2'b00;
    end else begin
      a_q <= {a_q[0], enc_a};
      b_q <= {b_q[0], enc_b};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= CNT_W'(FRAME_DIV);
    else if (frame_tick)
      cnt <= sample_en ? CNT_W'(FRAME_DIV) : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      edge_seen <= 1'b0;
    else if (sample_en)
      edge_seen <= !a_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dly_hi <= DLY_W'(INIT_DLY);
    else if (turn)
      dly_hi <= b_s ? dly_hi - DLY_W'(1) : dly_hi + DLY_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      prog_idx <= IDX_W'(2);
    else if (sample_en)
      prog_idx <= IDX_W'({prog_sw, 1'b0}) + IDX_W'(2);
  end
endmodule

// File: rtl/enc_delay_ctrl_chk.sv
module enc_delay_ctrl_chk #(
  parameter int DLY_W = 8,
  parameter int SW_W  = 4,
  parameter int IDX_W = SW_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic             a_s,
  input logic             b_s,
  input logic             edge_seen,
  input logic [SW_W-1:0]  prog_sw,
  input logic [DLY_W-1:0] dly_hi,
  input logic [IDX_W-1:0] prog_idx
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(dly_hi) && $stable(prog_idx)));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && a_s) |=> !edge_seen);

  // R4
  held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !a_s && edge_seen) |=> $stable(dly_hi));

  // R5
  right_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !a_s && !edge_seen && !b_s) |=> dly_hi == $past(dly_hi) + DLY_W'(1));

  // R6
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !a_s && !edge_seen && b_s) |=> dly_hi == $past(dly_hi) - DLY_W'(1));

  // R8
  prog_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> prog_idx == IDX_W'({$past(prog_sw), 1'b0}) + IDX_W'(2));
endmodule

bind enc_delay_ctrl enc_delay_ctrl_chk #(.DLY_W(DLY_W), .SW_W(SW_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .a_s(a_s), .b_s(b_s),
  .edge_seen(edge_seen), .prog_sw(prog_sw), .dly_hi(dly_hi), .prog_idx(prog_idx)
);

// File: tb/tb_enc_delay_ctrl.sv
module tb_enc_delay_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic       enc_a = 1'b1;
  logic       enc_b = 1'b0;
  logic [3:0] prog_sw = 4'd0;
  logic [7:0] dly_hi;
  logic [5:0] prog_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  enc_delay_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .enc_a(enc_a),
    .enc_b(enc_b), .prog_sw(prog_sw), .dly_hi(dly_hi), .prog_idx(prog_idx)
  );

  task automatic chk_dly(input string req, input logic [7:0] exp);
    checks++;
    if (dly_hi !== exp) begin
      failures++;
      $display("FAIL %s dly_hi actual=%0d expected=%0d", req, dly_hi, exp);
    end
  endtask

  task automatic chk_idx(input string req, input logic [5:0] exp);
    checks++;
    if (prog_idx !== exp) begin
      failures++;
      $display("FAIL %s prog_idx actual=%0d expected=%0d", req, prog_idx, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic set_enc(input logic a, input logic b);
    @(negedge clk);
    enc_a = a;
    enc_b = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic sample_with(input logic a, input logic b);
    set_enc(a, b);
    ticks(64);
  endtask

  task automatic t_reset();
    chk_dly("R1", 8'd0);
    chk_idx("R1", 6'd2);
  endtask

  task automatic t_cadence();
    sample_with(1'b1, 1'b0);
    chk_dly("R2", 8'd0);
    set_enc(1'b0, 1'b0);
    ticks(63);
    chk_dly("R2", 8'd0);
    ticks(1);
    chk_dly("R5", 8'd1);
  endtask

  task automatic t_hold();
    sample_with(1'b0, 1'b0);
    chk_dly("R4", 8'd1);
    sample_with(1'b0, 1'b1);
    chk_dly("R4", 8'd1);
  endtask

  task automatic t_release();
    sample_with(1'b1, 1'b0);
    chk_dly("R3", 8'd1);
    sample_with(1'b0, 1'b0);
    chk_dly("R3", 8'd2);
  endtask

  task automatic t_left();
    sample_with(1'b1, 1'b1);
    sample_with(1'b0, 1'b1);
    chk_dly("R6", 8'd1);
  endtask

  task automatic t_wrap();
    sample_with(1'b1, 1'b1);
    sample_with(1'b0, 1'b1);
    chk_dly("R6", 8'd0);
    sample_with(1'b1, 1'b1);
    sample_with(1'b0, 1'b1);
    chk_dly("R7", 8'd255);
    sample_with(1'b1, 1'b0);
    sample_with(1'b0, 1'b0);
    chk_dly("R7", 8'd0);
  endtask

  task automatic t_sync();
    sample_with(1'b1, 1'b0);
    ticks(63);
    @(negedge clk);
    enc_a = 1'b0;
    frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    chk_dly("R9", 8'd0);
    ticks(64);
    chk_dly("R9", 8'd1);
  endtask

  task automatic t_prog();
    set_enc(1'b1, 1'b0);
    ticks(32);
    prog_sw = 4'd5;
    ticks(31);
    chk_idx("R8", 6'd2);
    ticks(1);
    chk_idx("R8", 6'd12);
    prog_sw = 4'd15;
    ticks(64);
    chk_idx("R8", 6'd32);
    prog_sw = 4'd0;
    ticks(64);
    chk_idx("R8", 6'd2);
    chk_dly("R2", 8'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cadence();
    t_hold();
    t_release();
    t_left();
    t_wrap();
    t_sync();
    t_prog();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule